// File: doc/BRIEF.md
# Serial Digital Video Encoder

This block turns parallel standard-definition video words into the single-bit line stream. Each accepted word is expanded to ten bits when the source is 8 bits wide, checked for the timing reference preamble, delayed by two word slots, and then shifted out least significant bit first, one bit per bit-clock enable. Every bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1, and the scrambled bit drives NRZI coding before it reaches the output pin.

The fast clock runs the whole block, and `bit_en` stands for the ten-times bit clock. A parallel word is taken on a cycle where both `word_en` and `bit_en` are high. The source raises `word_en` once every ten bit enables. The two-slot delay lets the preamble flag line up with the start of the first preamble word on the serial line.

Top module: `sdv_encoder`

## Requirements
- R1: A synchronous reset clears the scrambler history, the NRZI level, the two delay slots and the shift register to zero, so `sdo` and `trs_found` read 0 after reset. While the words are zero after that, `sdo` stays 0.
- R2: A word is taken only in a cycle with `word_en` and `bit_en` both high. The word from two accepted slots earlier then starts serialization, bit 0 in that same cycle and bits 1..9 on the next nine bit enables. Once a word is used up, zeros are shifted.
- R3: Each serial bit d is scrambled as s = d XOR s(-4) XOR s(-9), where s(-k) is the scrambled bit from k bit enables earlier.
- R4: The NRZI level toggles when s is 1 and holds when s is 0. `sdo` shows the level one clock after the bit enable.
- R5: In a cycle with `bit_en` low, neither the serial output nor any internal state advances.
- R6: With `narrow_mode` = 1, only `din[7:0]` is used. 8'hFF becomes 10'h3FF, and any other value v becomes {v, 2'b00}, so 8'h00 gives 10'h000. `din[9:8]` has no effect.
- R7: A pulse on `trs_found` marks the preamble 3FF, 000, 000 in the accepted (expanded) word stream. It is one clock high, in the clock where `sdo` first shows the 3FF word's bit 0, which is the clock after the third preamble word is taken.
- R8: While `trs_off` = 1 in the cycle the third preamble word is taken, no pulse is produced. Serial data is unaffected.
- R9: With `narrow_mode` = 0, all ten bits of `din` are serialized unchanged.
- R10: Two accepted slots separate the taking of a word from the start of its serialization. Slots filled at reset carry 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Serial bit clock enable |
| word_en | input | 1 | Parallel word strobe, qualified by bit_en |
| din | input | 10 | Parallel video word |
| narrow_mode | input | 1 | 1: 8-bit source on din[7:0] |
| trs_off | input | 1 | 1: preamble detection suppressed |
| sdo | output | 1 | Scrambled NRZI serial output |
| trs_found | output | 1 | Preamble flag, aligned with the preamble's first serial bit |

## Verification
Loading a new word and emitting a bit always happen in the same cycle. In that cycle the preamble pulse can also fire while the scrambler takes bit 0 of the 3FF word, so the pulse and the first 3FF bit must appear at the outputs together. The bench creates this case by sending preambles in 10-bit mode, in 8-bit mode (FF, 00, 00) and again with `bit_en` gaps between bit slots. A behavioural queue model predicts `sdo` and `trs_found` for every clock and judges both. The gaps also show whether a disabled bit enable holds the output, and a run with detection switched off must give no pulse at all.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

    localparam int SDV_WORD_W   = 10;
    localparam int SDV_NARROW_W = 8;
    localparam int SDV_SCR_LEN  = 9;
    localparam int SDV_SCR_TAP  = 4;

    typedef enum logic {
        SRC_WIDE   = 1'b0,
        SRC_NARROW = 1'b1
    } src_mode_e;

endpackage

// File: rtl/sdv_word_prep.sv
module sdv_word_prep
    import sdv_pkg::*;
#(
    parameter int WORD_W   = SDV_WORD_W,
    parameter int NARROW_W = SDV_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              narrow_mode,
    input  logic              trs_off,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] oldest,
    output logic              trs_hit
);

    localparam int PAD_W = WORD_W - NARROW_W;
    localparam logic [WORD_W-1:0]   ALL_ONES = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0]   ALL_ZERO = {WORD_W{1'b0}};
    localparam logic [NARROW_W-1:0] N_ONES   = {NARROW_W{1'b1}};

    typedef struct packed {
        logic [WORD_W-1:0] slot_new;
        logic [WORD_W-1:0] slot_old;
    } prep_state_t;

    prep_state_t st_d, st_q;
    logic [WORD_W-1:0] expanded;
    src_mode_e         mode;

    assign mode = src_mode_e'(narrow_mode);

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (mode == SRC_NARROW) begin
                    if (din[NARROW_W-1:0] == N_ONES) begin
                        expanded = ALL_ONES;
                    end else begin
                        expanded = {din[NARROW_W-1:0], {PAD_W{1'b0}}};
                    end
                end else begin
                    expanded = din;
                end
            end
        end else begin : g_nopad
            assign expanded = din;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        trs_hit = 1'b0;
        if (take) begin
            trs_hit = !trs_off && (st_q.slot_old == ALL_ONES)
                      && (st_q.slot_new == ALL_ZERO) && (expanded == ALL_ZERO);
            st_d.slot_old = st_q.slot_new;
            st_d.slot_new = expanded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oldest = st_q.slot_old;

endmodule

// File: rtl/sdv_shifter.sv
module sdv_shifter
    import sdv_pkg::*;
#(
    parameter int WORD_W = SDV_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              bit_out
);

    typedef struct packed {
        logic [WORD_W-2:0] rest;
    } shift_state_t;

    shift_state_t sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        bit_out = 1'b0;
        if (bit_en) begin
            if (load) begin
                bit_out   = word_in[0];
                sh_d.rest = word_in[WORD_W-1:1];
            end else begin
                bit_out   = sh_q.rest[0];
                sh_d.rest = {1'b0, sh_q.rest[WORD_W-2:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/sdv_scr_nrzi.sv
module sdv_scr_nrzi
    import sdv_pkg::*;
#(
    parameter int SCR_LEN = SDV_SCR_LEN,
    parameter int SCR_TAP = SDV_SCR_TAP
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_in,
    output logic sdo
);

    typedef struct packed {
        logic [SCR_LEN-1:0] hist;
        logic               level;
    } line_state_t;

    line_state_t ln_d, ln_q;
    logic        scr_bit;

    generate
        if (SCR_TAP < SCR_LEN && SCR_TAP > 0) begin : g_taps
            assign scr_bit = bit_in ^ ln_q.hist[SCR_TAP-1] ^ ln_q.hist[SCR_LEN-1];
        end else begin : g_bad_taps
            assign scr_bit = bit_in ^ ln_q.hist[SCR_LEN-1];
        end
    endgenerate

    always_comb begin
        ln_d = ln_q;
        if (bit_en) begin
            ln_d.hist  = {ln_q.hist[SCR_LEN-2:0], scr_bit};
            ln_d.level = ln_q.level ^ scr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign sdo = ln_q.level;

endmodule

// File: rtl/sdv_encoder.sv
module sdv_encoder
    import sdv_pkg::*;
#(
    parameter int WORD_W   = SDV_WORD_W,
    parameter int NARROW_W = SDV_NARROW_W,
    parameter int SCR_LEN  = SDV_SCR_LEN,
    parameter int SCR_TAP  = SDV_SCR_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              word_en,
    input  logic [WORD_W-1:0] din,
    input  logic              narrow_mode,
    input  logic              trs_off,
    output logic              sdo,
    output logic              trs_found
);

    logic              take;
    logic [WORD_W-1:0] oldest;
    logic              trs_hit;
    logic              ser_bit;
    logic              flag_d, flag_q;

    assign take = word_en && bit_en;

    sdv_word_prep #(
        .WORD_W  (WORD_W),
        .NARROW_W(NARROW_W)
    ) u_prep (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .narrow_mode(narrow_mode),
        .trs_off    (trs_off),
        .din        (din),
        .oldest     (oldest),
        .trs_hit    (trs_hit)
    );

    sdv_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .load   (take),
        .word_in(oldest),
        .bit_out(ser_bit)
    );

    sdv_scr_nrzi #(
        .SCR_LEN(SCR_LEN),
        .SCR_TAP(SCR_TAP)
    ) u_line (
        .clk   (clk),
        .rst   (rst),
        .bit_en(bit_en),
        .bit_in(ser_bit),
        .sdo   (sdo)
    );

    always_comb begin
        flag_d = trs_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign trs_found = flag_q;

endmodule

// File: rtl/sdv_encoder_chk.sv
module sdv_encoder_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic word_en,
    input logic trs_off,
    input logic sdo,
    input logic trs_found
);

    // R1: reset leaves both outputs low
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!sdo && !trs_found));

    // R5: no bit enable, no movement on the line
    assert_hold_no_enable_R5: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(sdo));

    // R7: a pulse only follows a cycle that took a word
    assert_pulse_after_take_R7: assert property (@(posedge clk) disable iff (rst)
        trs_found |-> $past(word_en && bit_en));

    // R7: the pulse is a single clock wide
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        trs_found |=> !trs_found);

    // R8: detection off, no pulse
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        trs_off |=> !trs_found);

endmodule

bind sdv_encoder sdv_encoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .word_en  (word_en),
    .trs_off  (trs_off),
    .sdo      (sdo),
    .trs_found(trs_found)
);

// File: tb/test_sdv_encoder.sv
module test_sdv_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       word_en = 1'b0;
    logic [9:0] din = '0;
    logic       narrow_mode = 1'b0;
    logic       trs_off = 1'b0;
    logic       sdo;
    logic       trs_found;

    int    total = 0;
    int    bad = 0;
    bit    armed = 0;
    bit    finished = 0;
    string phase = "R1";
    int    pulses = 0;

    // reference model state
    int m_slots[$];
    int m_bits[$];
    int m_hist[$];
    int m_level;
    int m_trs;

    always #4 clk = ~clk;

    sdv_encoder i_sdv_encoder (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .word_en    (word_en),
        .din        (din),
        .narrow_mode(narrow_mode),
        .trs_off    (trs_off),
        .sdo        (sdo),
        .trs_found  (trs_found)
    );

    function automatic int expand(int d, bit nar);
        int v;
        if (!nar) return d & 1023;
        v = d & 255;
        if (v == 255) return 1023;
        return v * 4;
    endfunction

    task automatic model_reset();
        m_slots = {0, 0};
        m_bits  = {};
        m_hist  = {0, 0, 0, 0, 0, 0, 0, 0, 0};
        m_level = 0;
        m_trs   = 0;
    endtask

    task automatic model_step();
        int b, s, e, w;
        if (rst) begin
            model_reset();
            return;
        end
        m_trs = 0;
        if (!bit_en) return;
        if (word_en) begin
            e = expand(din, narrow_mode);
            m_trs = (!trs_off && m_slots[0] == 1023 && m_slots[1] == 0 && e == 0) ? 1 : 0;
            w = m_slots.pop_front();
            m_slots.push_back(e);
            m_bits = {};
            for (int i = 0; i < 10; i++) m_bits.push_back((w >> i) & 1);
        end
        b = (m_bits.size() > 0) ? m_bits.pop_front() : 0;
        s = b ^ m_hist[3] ^ m_hist[8];
        m_hist.push_front(s);
        void'(m_hist.pop_back());
        m_level = m_level ^ s;
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(bit r, bit be, bit we, int d);
        @(negedge clk);
        if (armed) begin
            check({phase, " sdo R2 R3 R4"}, int'(sdo), m_level);
            check({phase, " trs_found R7"}, int'(trs_found), m_trs);
            if (trs_found) pulses++;
        end
        rst = r; bit_en = be; word_en = we; din = d[9:0];
        model_step();
        armed = 1;
    endtask

    task automatic send_word(int d, int gap_pct);
        tick(0, 1, 1, d);
        for (int i = 1; i < 10; i++) begin
            while (gap_pct > 0 && $urandom_range(0, 99) < gap_pct)
                tick(0, 0, ($urandom_range(0, 1) == 1), $urandom_range(0, 1023));
            tick(0, 1, 0, $urandom_range(0, 1023));
        end
    endtask

    task automatic send_trs(bit nar, int gap_pct);
        send_word(nar ? 255 : 1023, gap_pct);
        send_word(nar ? ($urandom_range(0, 3) * 256) : 0, gap_pct);
        send_word(nar ? ($urandom_range(0, 3) * 256) : 0, gap_pct);
    endtask

    task automatic flush(int gap_pct);
        for (int i = 0; i < 3; i++) send_word($urandom_range(1, 1022), gap_pct);
    endtask

    initial begin
        model_reset();
        tick(1, 0, 0, 0);
        tick(1, 0, 0, 0);
        // R1: direct reset-state check and zero stream after reset
        @(negedge clk);
        check("R1 reset sdo", int'(sdo), 0);
        check("R1 reset trs_found", int'(trs_found), 0);
        phase = "R1 zero words";
        for (int k = 0; k < 6; k++) send_word(0, 0);
        check("R1 line stays low", int'(sdo), 0);

        // R9 R10: random 10-bit words, continuous enables
        phase = "R9 R10 wide random";
        narrow_mode = 0;
        for (int k = 0; k < 40; k++) send_word($urandom_range(0, 1023), 0);

        // R7: preamble in 10-bit mode
        phase = "R7 wide preamble";
        pulses = 0;
        for (int k = 0; k < 4; k++) begin
            send_trs(0, 0);
            flush(0);
        end
        check("R7 wide preamble pulse count", pulses, 4);

        // R8: detection switched off
        phase = "R8 detection off";
        trs_off = 1;
        pulses = 0;
        for (int k = 0; k < 4; k++) begin
            send_trs(0, 0);
            flush(0);
        end
        check("R8 no pulse while off", pulses, 0);
        trs_off = 0;

        // R6: 8-bit source, upper bits random
        phase = "R6 narrow";
        narrow_mode = 1;
        for (int k = 0; k < 30; k++) send_word($urandom_range(0, 1023), 0);
        pulses = 0;
        for (int k = 0; k < 3; k++) begin
            send_trs(1, 0);
            flush(0);
        end
        check("R6 narrow preamble pulse count", pulses, 3);
        for (int k = 0; k < 10; k++) send_word(($urandom_range(0, 3) * 256) + 255, 0);

        // R5: gaps in bit enable, preamble across gaps
        phase = "R5 gaps";
        narrow_mode = 0;
        pulses = 0;
        for (int k = 0; k < 20; k++) send_word($urandom_range(0, 1023), 35);
        for (int k = 0; k < 3; k++) begin
            send_trs(0, 35);
            flush(35);
        end
        check("R5 R7 preamble pulse count with gaps", pulses, 3);

        // R1: mid-stream reset
        phase = "R1 mid reset";
        tick(1, 1, 1, 1023);
        for (int k = 0; k < 4; k++) send_word(0, 0);
        check("R1 line low after mid reset", int'(sdo), 0);

        tick(0, 0, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule